// File: doc/BRIEF.md
# Quadrant-Based Frequency Detector

This block decides whether a recovered clock runs faster or slower than the incoming data rate. Two bang-bang samplers upstream judge each data edge against the clock: one against an in-phase clock, the other against a clock shifted by a quarter period. Each sampler's result arrives here already filtered, as an early flag and a late flag. The I and Q verdicts together place the data edges in one of four quarters of the clock period.

The block keeps the quadrant of the last accepted decision. A step to the next higher index, modulo 4, means the edges drift forward and the clock is fast. A step to the next lower index means the clock is slow. One such step gives a one-cycle pulse on the matching output. A jump of two quadrants says nothing about direction, so the block drops it. An arming latch blocks any pulse until the first quadrant after reset is known. A simple lock flag rises once the quadrant has held steady for a set number of decisions.

Decisions arrive as a valid/ready stream. The block never applies back-pressure: `dec_ready_o` is always high, and every cycle with `dec_valid_i` high is taken as one decision beat. The status outputs are plain level or pulse signals.

Top module: `qfd_freq_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `quad_o` is 0 and `quad_valid_o`, `faster_o`, `slower_o` and `locked_o` are all 0.
- R2: A path's verdict is well formed when exactly one of its early and late flags is high. For a well-formed beat the quadrant is {I early, Q early} with: I late/Q late = 0, I early/Q late = 1, I early/Q early = 2, I late/Q early = 3. `quad_o` shows the new value in the cycle after the beat, whenever the beat is accepted as a first identification or as a one-step move.
- R3: A move from the held quadrant to (held+1) mod 4 (including 3 to 0) raises `faster_o` for exactly one cycle, in the cycle after the beat.
- R4: A move to (held+3) mod 4 (including 0 to 3) raises `slower_o` for exactly one cycle, in the cycle after the beat.
- R5: The first well-formed beat after reset sets `quad_valid_o` and loads `quad_o`, but it raises neither `faster_o` nor `slower_o`. `quad_valid_o` stays high until reset.
- R6: A beat two quadrants away from the held one leaves `quad_o` and `locked_o` unchanged and raises no pulse.
- R7: A beat with a malformed verdict on either path (both flags high or both flags low) has no effect on any output.
- R8: `locked_o` rises in the cycle after the LOCK_COUNT-th consecutive accepted beat that names the same quadrant, counting the beat that set that quadrant. It falls in the same cycle as any `faster_o` or `slower_o` pulse.
- R9: `dec_ready_o` is always 1. Cycles with `dec_valid_i` low change no output, and the pulses return to 0.
- R10: `faster_o` and `slower_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | Decision beat present |
| dec_ready_o | output | 1 | Always high; the block never stalls |
| i_early_i | input | 1 | In-phase path says data is early |
| i_late_i | input | 1 | In-phase path says data is late |
| q_early_i | input | 1 | Quadrature path says data is early |
| q_late_i | input | 1 | Quadrature path says data is late |
| quad_o | output | 2 | Quadrant currently holding the data edges |
| quad_valid_o | output | 1 | A quadrant has been identified since reset |
| faster_o | output | 1 | One-cycle pulse: clock faster than data |
| slower_o | output | 1 | One-cycle pulse: clock slower than data |
| locked_o | output | 1 | Quadrant steady for LOCK_COUNT decisions |

## Verification
The bench builds the block with LOCK_COUNT set to 3 rather than the default 4. The lock count then saturates after a short run of equal beats, so a locked state, its loss on a shift, and relocking all fit inside a brief directed phase. Within that budget a long random phase can still lock and unlock many times. Since the default is not 3, the bench also checks that the threshold is taken from the parameter and not built in as a constant. The random phase mixes malformed verdicts, idle cycles, and steps of 0 to 3 quadrants, so both wrap directions and the two-quadrant jump come up many times.

// File: rtl/qfd_pkg.sv
package qfd_pkg;

  typedef logic [1:0] quad_t;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_SKIP = 2'd2,
    STEP_DOWN = 2'd3
  } step_e;

  // Distance between two quadrants, modulo 4.
  function automatic step_e classify_step(input quad_t now_q, input quad_t held_q);
    quad_t diff;
    diff = now_q - held_q;
    return step_e'(diff);
  endfunction

endpackage

// File: rtl/qfd_quadrant_map.sv
module qfd_quadrant_map
  import qfd_pkg::*;
(
  input  logic  i_early_i,
  input  logic  i_late_i,
  input  logic  q_early_i,
  input  logic  q_late_i,
  output quad_t quad_o,
  output logic  pair_ok_o
);

  logic i_ok, q_ok;

  always_comb begin
    i_ok      = i_early_i ^ i_late_i;
    q_ok      = q_early_i ^ q_late_i;
    pair_ok_o = i_ok & q_ok;
    unique case ({i_early_i, q_early_i})
      2'b00:   quad_o = 2'd0;
      2'b10:   quad_o = 2'd1;
      2'b11:   quad_o = 2'd2;
      default: quad_o = 2'd3;
    endcase
  end

endmodule

// File: rtl/qfd_shift_tracker.sv
module qfd_shift_tracker
  import qfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_i,
  input  quad_t quad_i,
  output quad_t quad_o,
  output logic  armed_o,
  output logic  faster_o,
  output logic  slower_o,
  output logic  first_o,
  output logic  hold_o,
  output logic  shift_o
);

  quad_t held_q;
  logic  armed_q;
  step_e step;
  logic  up, down;

  always_comb begin
    step    = classify_step(quad_i, held_q);
    first_o = take_i & ~armed_q;
    hold_o  = take_i & armed_q & (step == STEP_HOLD);
    up      = take_i & armed_q & (step == STEP_UP);
    down    = take_i & armed_q & (step == STEP_DOWN);
    shift_o = up | down;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q   <= '0;
      armed_q  <= 1'b0;
      faster_o <= 1'b0;
      slower_o <= 1'b0;
    end else begin
      armed_q  <= armed_q | take_i;
      faster_o <= up;
      slower_o <= down;
      if (first_o | up | down) held_q <= quad_i;
    end
  end

  assign quad_o  = held_q;
  assign armed_o = armed_q;

  assert_first_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !armed_q) |=> (!faster_o && !slower_o && armed_q));

  assert_skip_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && armed_q && quad_t'(quad_i - held_q) == 2'd2) |=> ($stable(held_q) && !faster_o && !slower_o));

  assert_arm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

endmodule

// File: rtl/qfd_lock_counter.sv
module qfd_lock_counter #(
  parameter int LOCK_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first_i,
  input  logic hold_i,
  input  logic shift_i,
  output logic locked_o
);

  localparam int CW = $clog2(LOCK_COUNT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_COUNT);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (first_i | shift_i) begin
      run_q <= ONE;
    end else if (hold_i && run_q < LIMIT) begin
      run_q <= run_q + ONE;
    end
  end

  assign locked_o = (run_q >= LIMIT);

  generate
    if (LOCK_COUNT > 1) begin : g_unlock_chk
      assert_shift_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> !locked_o);
    end
  endgenerate

  assert_run_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT);

endmodule

// File: rtl/qfd_freq_detector.sv
module qfd_freq_detector
  import qfd_pkg::*;
#(
  parameter int LOCK_COUNT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dec_valid_i,
  output logic       dec_ready_o,
  input  logic       i_early_i,
  input  logic       i_late_i,
  input  logic       q_early_i,
  input  logic       q_late_i,
  output logic [1:0] quad_o,
  output logic       quad_valid_o,
  output logic       faster_o,
  output logic       slower_o,
  output logic       locked_o
);

  quad_t map_quad;
  logic  pair_ok;
  logic  take;
  logic  first_ev, hold_ev, shift_ev;

  qfd_quadrant_map u_map (
    .i_early_i (i_early_i),
    .i_late_i  (i_late_i),
    .q_early_i (q_early_i),
    .q_late_i  (q_late_i),
    .quad_o    (map_quad),
    .pair_ok_o (pair_ok)
  );

  assign take        = dec_valid_i & pair_ok;
  assign dec_ready_o = 1'b1;

  qfd_shift_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .quad_i   (map_quad),
    .quad_o   (quad_o),
    .armed_o  (quad_valid_o),
    .faster_o (faster_o),
    .slower_o (slower_o),
    .first_o  (first_ev),
    .hold_o   (hold_ev),
    .shift_o  (shift_ev)
  );

  qfd_lock_counter #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .first_i  (first_ev),
    .hold_i   (hold_ev),
    .shift_i  (shift_ev),
    .locked_o (locked_o)
  );

  assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(faster_o && slower_o));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> (!faster_o && !slower_o && $stable(quad_o) && $stable(locked_o)));

  assert_malformed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && !(i_early_i ^ i_late_i)) |=> (!faster_o && !slower_o && $stable(quad_o)));

  assert_pulse_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (faster_o || slower_o) |-> (!locked_o || LOCK_COUNT == 1));

endmodule

// File: tb/qfd_freq_detector_tb.sv
`timescale 1ns/1ps
module qfd_freq_detector_tb;

  localparam int LK = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic ie = 1'b0, il = 1'b0, qe = 1'b0, ql = 1'b0;
  logic dec_ready;
  logic [1:0] quad;
  logic quad_valid, faster, slower, locked;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  // reference state
  int m_q = 0, m_cnt = 0;
  bit m_arm = 0, m_fast = 0, m_slow = 0;

  always #4 clk = ~clk;

  qfd_freq_detector #(.LOCK_COUNT(LK)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid), .dec_ready_o(dec_ready),
    .i_early_i(ie), .i_late_i(il), .q_early_i(qe), .q_late_i(ql),
    .quad_o(quad), .quad_valid_o(quad_valid), .faster_o(faster),
    .slower_o(slower), .locked_o(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    int nq, d;
    m_fast = 0;
    m_slow = 0;
    if (!rst_n) begin
      m_q = 0; m_cnt = 0; m_arm = 0;
    end else if (dec_valid && (ie != il) && (qe != ql)) begin
      if (!ie && !qe) nq = 0;
      else if (ie && !qe) nq = 1;
      else if (ie && qe) nq = 2;
      else nq = 3;
      if (!m_arm) begin
        m_arm = 1; m_q = nq; m_cnt = 1;
      end else begin
        d = (nq - m_q + 4) % 4;
        if (d == 0) begin
          if (m_cnt < LK) m_cnt++;
        end else if (d == 1) begin
          m_fast = 1; m_q = nq; m_cnt = 1;
        end else if (d == 3) begin
          m_slow = 1; m_q = nq; m_cnt = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 quad", int'(quad), m_q);
      chk("R5 quad_valid", int'(quad_valid), int'(m_arm));
      chk("R3 faster", int'(faster), int'(m_fast));
      chk("R4 slower", int'(slower), int'(m_slow));
      chk("R8 locked", int'(locked), int'(m_cnt >= LK));
      chk("R9 ready", int'(dec_ready), 1);
    end
  end

  task automatic set_q(input int q);
    ie = (q == 1 || q == 2);
    qe = (q == 2 || q == 3);
    il = !ie;
    ql = !qe;
  endtask

  // one cycle with the given inputs, then sample at the following negedge
  task automatic beat(input bit v, input int q);
    dec_valid = v;
    set_q(q);
    @(posedge clk);
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic beat_raw(input bit v, input bit a, input bit b, input bit c, input bit e);
    dec_valid = v; ie = a; il = b; qe = c; ql = e;
    @(posedge clk);
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 quad in reset", int'(quad), 0);
    chk("R1 quad_valid in reset", int'(quad_valid), 0);
    chk("R1 faster in reset", int'(faster), 0);
    chk("R1 slower in reset", int'(slower), 0);
    chk("R1 locked in reset", int'(locked), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 quad after reset", int'(quad), 0);
    chk("R1 quad_valid after reset", int'(quad_valid), 0);
    cmp_on = 1'b1;

    beat(1, 1);
    chk("R5 first beat no pulse", int'(faster | slower), 0);
    chk("R2 mapping I early Q late", int'(quad), 1);
    chk("R5 armed", int'(quad_valid), 1);
    beat(1, 2);
    chk("R3 up step", int'(faster), 1);
    beat(0, 2);
    chk("R10 pulse one cycle", int'(faster), 0);
    beat(1, 3);
    beat(1, 0);
    chk("R3 wrap 3 to 0", int'(faster), 1);
    chk("R2 mapping both late", int'(quad), 0);
    beat(1, 3);
    chk("R4 wrap 0 to 3", int'(slower), 1);
    chk("R10 exclusive", int'(faster & slower), 0);
    beat(1, 2);
    chk("R4 down step", int'(slower), 1);
    beat(1, 0);
    chk("R6 skip keeps quad", int'(quad), 2);
    chk("R6 skip no pulse", int'(faster | slower), 0);
    beat_raw(1, 1, 1, 0, 1);
    chk("R7 both I flags ignored", int'(quad), 2);
    beat_raw(1, 0, 0, 1, 0);
    chk("R7 no I flag ignored", int'(quad), 2);
    beat(0, 3);
    chk("R9 idle beat ignored", int'(quad), 2);
    beat(1, 2);
    chk("R8 not yet locked", int'(locked), 0);
    beat(1, 2);
    chk("R8 locked after LK equal beats", int'(locked), 1);
    beat(1, 0);
    chk("R6 skip keeps lock", int'(locked), 1);
    beat(1, 3);
    chk("R8 shift unlocks", int'(locked), 0);
    chk("R3 shift pulse", int'(faster), 1);

    for (int k = 0; k < 3000; k++) begin
      int r;
      int q;
      r = $urandom_range(0, 9);
      q = (m_q + $urandom_range(0, 3) * ($urandom_range(0, 2) == 0 ? 1 : 0)) % 4;
      if (r == 0) beat_raw(1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else if (r == 1) beat(0, $urandom_range(0, 3));
      else beat(1, q);
    end

    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 reset again quad_valid", int'(quad_valid), 0);
    chk("R1 reset again locked", int'(locked), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule